// File: doc/BRIEF.md
# Pin I/O Controller with Per-Pin Interrupt Detection

This block gives software control of a bank of general-purpose pins through a small word-addressed register bus. Every pin has a direction bit and an output latch. Its input is read back through a two-flop synchronizer. Each pin also has an interrupt detector. Software sets the detector to fire on a falling edge, a rising edge, a low level, a high level or both edges.

A detection on an enabled pin sets a sticky pending bit. Software acknowledges it by writing a one to the clear register. Separate write-one registers set and clear the per-pin mask. Every pending pin that is not masked drives a single interrupt line.

A small state machine watches the reset register. It has three named states. SR_RUN is normal operation. SR_ARMED is entered when a 1 is written to the reset register. SR_PURGE lasts one cycle: it is entered when a 0 is written while in SR_ARMED. In SR_PURGE every other register goes back to its default value.

The state machine has three named transitions:
- start: SR_RUN to SR_ARMED, on a write of 1 to the reset register.
- commit: SR_ARMED to SR_PURGE, on a write of 0 to the reset register.
- finish: SR_PURGE to SR_RUN, on the next clock with no condition.

Two other cases hold the state. A write of 1 in SR_ARMED stays in SR_ARMED. A write of 0 in SR_RUN stays in SR_RUN.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the controller reads as follows. Enable (0x00) reads 0, direction (0x20) reads 0, output latch (0x18) reads 0, mode registers (0x24, 0x28) read 0 and the mask (read at 0x10) reads all ones for the implemented pins. irq_out and pin_oe are 0.
- R2: Direction bit n at 0x20 set to 1 drives pin_oe[n] high. pin_out follows the output latch written at 0x18.
- R3: Register 0x1C returns pin_in through two flops. After a pin change it shows the old value after one clock edge and the new value after two.
- R4: Edge modes are encoded as 0 = falling, 1 = rising and 4 = both edges. A matching edge on an enabled pin sets that pin's pending bit. The bit stays set after the pin returns to its old level. An edge of the wrong direction sets nothing. irq_out rises on the third clock edge after the pin changes.
- R5: Level modes are encoded as 2 = low and 3 = high. While the level is present the pending bit is set, and a clear has no effect. Once the level is gone a clear removes the bit.
- R6: Pin n < 8 keeps its 3-bit mode in bits [4n+2:4n] of mode register 0 (0x24). Pins 8 and above use mode register 1 (0x28) at bits [4(n-8)+2:4(n-8)]. Codes 5, 6 and 7 detect nothing.
- R7: A pin whose enable bit at 0x00 is 0 never sets its pending bit.
- R8: Writing 1 to bit n of 0x0C clears pin n's pending bit. Writing 0 leaves it alone.
- R9: Writing 1 to bit n of 0x10 masks pin n. Writing 1 to bit n of 0x14 unmasks it. Zero bits have no effect. 0x10 reads back the current mask.
- R10: Register 0x08 shows pending bits before masking. Register 0x04 shows the pending bits that are not masked. irq_out is high while any pending pin is unmasked. Writes to 0x04 and 0x08 are ignored.
- R11: Writing 1 and then 0 to 0x3C returns every other register and every pending bit to its reset value. 0x3C reads 1 in SR_ARMED and 0 otherwise. Writing 0 while in SR_RUN changes nothing.
- R12: Register bits at and above NUM_PINS read 0, and written values there are ignored. Unlisted offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output latch value |
| pin_oe | output | NUM_PINS | Output enable per pin |
| irq_out | output | 1 | Combined interrupt |

## Verification
- A register write takes effect at the clock edge that samples it, so the next read shows the new value.
- A pin change reaches the input register after two edges. It reaches the pending bits and irq_out after three.
- A commit write to the reset register restores the defaults one edge later, as the state machine passes through SR_PURGE.
- The bench drives pins and bus signals at falling clock edges and reads one time unit later. It counts the edges before each timing check (one and two for the input register, two and three for irq_out) and waits at least four edges before reading a pending result.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 6;
    localparam int MODE_W      = 3;
    localparam int MODE_STRIDE = 4;
    localparam int MODE_PER_RG = DATA_W / MODE_STRIDE;

    localparam logic [ADDR_W-1:0] OFS_EN    = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_MSET  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_MCLR  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_OUT   = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_IN    = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_MODE0 = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_MODE1 = 6'h28;
    localparam logic [ADDR_W-1:0] OFS_SRST  = 6'h3C;

    localparam logic [MODE_W-1:0] MD_FALL = 3'd0;
    localparam logic [MODE_W-1:0] MD_RISE = 3'd1;
    localparam logic [MODE_W-1:0] MD_LOW  = 3'd2;
    localparam logic [MODE_W-1:0] MD_HIGH = 3'd3;
    localparam logic [MODE_W-1:0] MD_BOTH = 3'd4;

    typedef enum logic [1:0] {
        SR_RUN   = 2'd0,
        SR_ARMED = 2'd1,
        SR_PURGE = 2'd2
    } srst_state_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int NUM_PINS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] async_in,
    output logic [NUM_PINS-1:0] sync_out
);
    logic [NUM_PINS-1:0] meta_q;
    logic [NUM_PINS-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            purge,
    input  logic [NUM_PINS-1:0]             level_in,
    input  logic [NUM_PINS-1:0]             en,
    input  logic [NUM_PINS-1:0]             clr,
    input  logic [NUM_PINS-1:0][MODE_W-1:0] mode,
    output logic [NUM_PINS-1:0]             pend
);
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic prev_q;
        logic hit;
        logic pend_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= level_in[g];
        end

        always_comb begin
            case (mode[g])
                MD_FALL: hit = prev_q & ~level_in[g];
                MD_RISE: hit = ~prev_q & level_in[g];
                MD_LOW:  hit = ~level_in[g];
                MD_HIGH: hit = level_in[g];
                MD_BOTH: hit = prev_q ^ level_in[g];
                default: hit = 1'b0;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               pend_q <= 1'b0;
            else if (purge)           pend_q <= 1'b0;
            else if (hit && en[g])    pend_q <= 1'b1;
            else if (clr[g])          pend_q <= 1'b0;
        end

        assign pend[g] = pend_q;
    end
endmodule

// File: rtl/gpio_srst_fsm.sv
module gpio_srst_fsm
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_srst,
    input  logic wr_bit,
    output logic purge,
    output logic armed
);
    srst_state_e state_q;
    srst_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SR_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_RUN:   if (wr_srst && wr_bit)  state_d = SR_ARMED;
            SR_ARMED: if (wr_srst && !wr_bit) state_d = SR_PURGE;
            SR_PURGE: state_d = SR_RUN;
            default:  state_d = SR_RUN;
        endcase
    end

    always_comb begin
        purge = 1'b0;
        armed = 1'b0;
        unique case (state_q)
            SR_RUN:   ;
            SR_ARMED: armed = 1'b1;
            SR_PURGE: purge = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [5:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq_out
);
    localparam int PAD = DATA_W - NUM_PINS;

    logic [NUM_PINS-1:0]             en_q, mask_q, out_q, dir_q;
    logic [NUM_PINS-1:0][MODE_W-1:0] mode_q;
    logic [NUM_PINS-1:0]             sync_lvl, pend_q, clr_vec;
    logic [NUM_PINS-1:0]             wpin;
    logic                            wr, purge, armed;
    logic [DATA_W-1:0]               mode0_rd, mode1_rd;

    assign wr      = bus_sel & bus_wr;
    assign wpin    = bus_wdata[NUM_PINS-1:0];
    assign clr_vec = (wr && bus_addr == OFS_CLR) ? wpin : '0;

    gpio_pin_sync #(.NUM_PINS(NUM_PINS)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_lvl)
    );

    gpio_irq_detect #(.NUM_PINS(NUM_PINS)) i_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .purge    (purge),
        .level_in (sync_lvl),
        .en       (en_q),
        .clr      (clr_vec),
        .mode     (mode_q),
        .pend     (pend_q)
    );

    gpio_srst_fsm i_srst (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_srst (wr && bus_addr == OFS_SRST),
        .wr_bit  (bus_wdata[0]),
        .purge   (purge),
        .armed   (armed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '1;
            out_q  <= '0;
            dir_q  <= '0;
        end else if (purge) begin
            en_q   <= '0;
            mask_q <= '1;
            out_q  <= '0;
            dir_q  <= '0;
        end else if (wr) begin
            case (bus_addr)
                OFS_EN:   en_q   <= wpin;
                OFS_MSET: mask_q <= mask_q | wpin;
                OFS_MCLR: mask_q <= mask_q & ~wpin;
                OFS_OUT:  out_q  <= wpin;
                OFS_DIR:  dir_q  <= wpin;
                default:  ;
            endcase
        end
    end

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_mode
        localparam logic [ADDR_W-1:0] MY_OFS = (n < MODE_PER_RG) ? OFS_MODE0 : OFS_MODE1;
        localparam int POS = (n % MODE_PER_RG) * MODE_STRIDE;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         mode_q[n] <= '0;
            else if (purge)                     mode_q[n] <= '0;
            else if (wr && bus_addr == MY_OFS)  mode_q[n] <= bus_wdata[POS +: MODE_W];
        end
    end

    always_comb begin
        mode0_rd = '0;
        mode1_rd = '0;
        for (int n = 0; n < NUM_PINS; n++) begin
            if (n < MODE_PER_RG) mode0_rd[(n % MODE_PER_RG)*MODE_STRIDE +: MODE_W] = mode_q[n];
            else                 mode1_rd[(n % MODE_PER_RG)*MODE_STRIDE +: MODE_W] = mode_q[n];
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_EN:    bus_rdata = {{PAD{1'b0}}, en_q};
            OFS_STAT:  bus_rdata = {{PAD{1'b0}}, pend_q & ~mask_q};
            OFS_RAW:   bus_rdata = {{PAD{1'b0}}, pend_q};
            OFS_MSET:  bus_rdata = {{PAD{1'b0}}, mask_q};
            OFS_OUT:   bus_rdata = {{PAD{1'b0}}, out_q};
            OFS_IN:    bus_rdata = {{PAD{1'b0}}, sync_lvl};
            OFS_DIR:   bus_rdata = {{PAD{1'b0}}, dir_q};
            OFS_MODE0: bus_rdata = mode0_rd;
            OFS_MODE1: bus_rdata = mode1_rd;
            OFS_SRST:  bus_rdata = {{(DATA_W-1){1'b0}}, armed};
            default:   bus_rdata = '0;
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq_out = |(pend_q & ~mask_q);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [5:0]          bus_addr,
    input logic [31:0]         bus_wdata,
    input logic                irq_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] en_q,
    input logic [NUM_PINS-1:0] mask_q,
    input logic [NUM_PINS-1:0] pend_q,
    input logic                purge
);
    logic wr;
    assign wr = bus_sel & bus_wr;

    // R9
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_MSET) |=>
        ((mask_q & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));

    // R9
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_MCLR && !purge) |=>
        ((mask_q & $past(bus_wdata[NUM_PINS-1:0])) == '0));

    // R8
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr && bus_addr == OFS_CLR) && !purge) |=>
        ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R11
    purge_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        purge |=> (en_q == '0 && mask_q == '1 && pin_oe == '0 && pend_q == '0));

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (pend_q != '0));

    // R2
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr && bus_addr == OFS_DIR) && !purge) |=> $stable(pin_oe));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .pin_oe    (pin_oe),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .pend_q    (pend_q),
    .purge     (purge)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
    localparam int NP = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq_out;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    gpio_irq_ctrl #(.NUM_PINS(NP)) i_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd_reg(a, v);
        chk(tag, v, exp);
    endtask

    task automatic drive_pins(input logic [NP-1:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk("R1 enable", 6'h00, 32'h0);
        rd_chk("R1 mask", 6'h10, 32'hFFF);
        rd_chk("R1 dir", 6'h20, 32'h0);
        rd_chk("R1 out", 6'h18, 32'h0);
        rd_chk("R1 mode0", 6'h24, 32'h0);
        rd_chk("R1 mode1", 6'h28, 32'h0);
        chk("R1 irq", {31'h0, irq_out}, 32'h0);
        chk("R1 oe", {20'h0, pin_oe}, 32'h0);
    endtask

    task automatic t_output();
        wr_reg(6'h20, 32'h0A5);
        wr_reg(6'h18, 32'hFFFF_FFFF);
        rd_chk("R12 out upper bits", 6'h18, 32'hFFF);
        chk("R2 pin_out", {20'h0, pin_out}, 32'hFFF);
        chk("R2 pin_oe", {20'h0, pin_oe}, 32'h0A5);
        rd_chk("R2 dir readback", 6'h20, 32'h0A5);
    endtask

    task automatic t_input();
        drive_pins(12'h5A3);
        rd_chk("R3 one edge", 6'h1C, 32'h0);
        rd_chk("R3 two edges", 6'h1C, 32'h5A3);
        drive_pins(12'h000);
        idle(4);
    endtask

    task automatic t_edges();
        wr_reg(6'h24, 32'h401);
        wr_reg(6'h14, 32'h7);
        wr_reg(6'h00, 32'h7);
        idle(3);
        drive_pins(12'h005);
        @(negedge clk);
        @(negedge clk);
        chk("R4 irq before third edge", {31'h0, irq_out}, 32'h0);
        @(negedge clk);
        chk("R4 irq at third edge", {31'h0, irq_out}, 32'h1);
        idle(2);
        rd_chk("R4 rising and both", 6'h08, 32'h005);
        drive_pins(12'h007);
        idle(4);
        rd_chk("R4 rise ignored by falling mode", 6'h08, 32'h005);
        drive_pins(12'h000);
        idle(4);
        rd_chk("R4 falling detected", 6'h08, 32'h007);
        wr_reg(6'h0C, 32'h0);
        rd_chk("R8 zero clear no effect", 6'h08, 32'h007);
        wr_reg(6'h0C, 32'h7);
        rd_chk("R8 cleared", 6'h08, 32'h0);
        chk("R8 irq low", {31'h0, irq_out}, 32'h0);
        drive_pins(12'h004);
        idle(4);
        wr_reg(6'h0C, 32'h4);
        drive_pins(12'h000);
        idle(4);
        rd_chk("R4 both-edge falling", 6'h08, 32'h004);
        wr_reg(6'h0C, 32'h4);
    endtask

    task automatic t_level();
        wr_reg(6'h28, 32'h230);
        rd_chk("R6 mode1 layout", 6'h28, 32'h230);
        wr_reg(6'h14, 32'h600);
        wr_reg(6'h00, 32'h607);
        idle(1);
        rd_chk("R5 low level pending", 6'h08, 32'h400);
        wr_reg(6'h0C, 32'h400);
        rd_chk("R5 clear ignored while low", 6'h08, 32'h400);
        drive_pins(12'h400);
        idle(4);
        wr_reg(6'h0C, 32'h400);
        rd_chk("R5 clear after level gone", 6'h08, 32'h0);
        drive_pins(12'h600);
        idle(4);
        rd_chk("R5 high level pending", 6'h08, 32'h200);
        wr_reg(6'h0C, 32'h200);
        rd_chk("R5 clear ignored while high", 6'h08, 32'h200);
    endtask

    task automatic t_mask();
        wr_reg(6'h10, 32'h200);
        rd_chk("R10 masked status", 6'h04, 32'h0);
        rd_chk("R10 raw unmasked view", 6'h08, 32'h200);
        chk("R10 irq masked", {31'h0, irq_out}, 32'h0);
        wr_reg(6'h10, 32'h0);
        rd_chk("R9 mask readback", 6'h10, 32'hBF8);
        wr_reg(6'h14, 32'h200);
        rd_chk("R10 status unmasked", 6'h04, 32'h200);
        chk("R10 irq unmasked", {31'h0, irq_out}, 32'h1);
        wr_reg(6'h14, 32'h0);
        rd_chk("R9 zero clear no effect", 6'h10, 32'h9F8);
        drive_pins(12'h400);
        idle(4);
        wr_reg(6'h0C, 32'h200);
        rd_chk("R8 level clear", 6'h08, 32'h0);
    endtask

    task automatic t_bad_mode_and_enable();
        wr_reg(6'h24, 32'h5401);
        rd_chk("R6 mode0 layout", 6'h24, 32'h5401);
        wr_reg(6'h00, 32'h60F);
        drive_pins(12'h408);
        idle(4);
        drive_pins(12'h400);
        idle(4);
        rd_chk("R6 code 5 detects nothing", 6'h08, 32'h0);
        drive_pins(12'h420);
        idle(4);
        drive_pins(12'h400);
        idle(4);
        rd_chk("R7 disabled pin quiet", 6'h08, 32'h0);
    endtask

    task automatic t_soft_reset();
        wr_reg(6'h00, 32'hFFFF_FFFF);
        rd_chk("R12 enable upper bits", 6'h00, 32'hFFF);
        rd_chk("R12 unlisted offset", 6'h2C, 32'h0);
        wr_reg(6'h08, 32'hFFF);
        rd_chk("R10 raw write ignored", 6'h08, 32'h0);
        wr_reg(6'h3C, 32'h0);
        rd_chk("R11 lone zero no effect", 6'h00, 32'hFFF);
        wr_reg(6'h3C, 32'h1);
        rd_chk("R11 armed readback", 6'h3C, 32'h1);
        rd_chk("R11 armed keeps regs", 6'h00, 32'hFFF);
        wr_reg(6'h3C, 32'h0);
        idle(1);
        rd_chk("R11 enable default", 6'h00, 32'h0);
        rd_chk("R11 mask default", 6'h10, 32'hFFF);
        rd_chk("R11 mode0 default", 6'h24, 32'h0);
        rd_chk("R11 out default", 6'h18, 32'h0);
        rd_chk("R11 reset reg idle", 6'h3C, 32'h0);
        chk("R11 oe default", {20'h0, pin_oe}, 32'h0);
        chk("R11 irq low", {31'h0, irq_out}, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_output();
        t_input();
        t_edges();
        t_level();
        t_mask();
        t_bad_mode_and_enable();
        t_soft_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule